// File: doc/BRIEF.md
# PWM Double-Buffer Reload Controller

This block decides when the software-written (outer) copy of a PWM submodule's double-buffered registers moves into the active (inner) copy. It receives compare pulses from the timebase: one at the end of the period and one at a programmable half-cycle point, which need not be the midpoint. It counts these as reload opportunities. Each source counts only when its own enable bit is set. A 4-bit frequency value decimates the opportunities, so a local reload happens on every (value+1)-th one.

A reload moves data only when software has armed the load-okay flag. The flag clears by itself on the edge where the transfer takes place. An immediate mode skips the wait for a reload event. A select input lets the submodule follow a reload pulse broadcast by a primary submodule instead of its own. The controller puts its own reload as a pulse on a master output for other submodules and on an opportunity output for an external trigger unit. One example buffered data register is included so the transfer can be seen at the ports.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset, `load_strobe_o`, `reload_opp_o`, `master_reload_o` and `ldok_o` are 0, `active_o` is 0 and the opportunity count is 0.
- R2: A full-cycle compare pulse counts as an opportunity only while `full_en_i` is 1. A half-cycle compare pulse counts only while `half_en_i` is 1. When both pulses arrive in the same cycle with both enables set, they count as one opportunity.
- R3: With `reload_freq_i` = v, a local reload occurs on the (v+1)-th opportunity counted since reset or since the previous local reload. `reload_opp_o` is 1 for the one cycle after the clock edge that samples that opportunity.
- R4: A reload event with `ldok_o` = 0 produces no load strobe, and `active_o` keeps its value.
- R5: A selected reload event with `ldok_o` = 1 makes `load_strobe_o` 1 for one cycle after the sampling edge. On that same edge `active_o` takes the outer register value and `ldok_o` returns to 0. If a set request arrives in the same cycle, the clear wins.
- R6: While `imm_load_i` = 1, `ldok_o` = 1 causes a load on the next edge without any compare pulse.
- R7: While `use_master_i` = 1, loads follow `master_reload_i` and local reloads cause no load. While `use_master_i` = 0, `master_reload_i` is ignored.
- R8: `master_reload_o` carries the same one-cycle local reload pulse as `reload_opp_o`, whatever the setting of `use_master_i`.
- R9: With both enables clear, no local reload occurs and compare pulses are ignored, but immediate loads still work.
- R10: The opportunity count returns to zero on every local reload, so the next reload again needs v+1 opportunities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| full_cmp_i | input | 1 | Period-end compare pulse |
| half_cmp_i | input | 1 | Half-cycle compare pulse |
| full_en_i | input | 1 | Count period-end compares as opportunities |
| half_en_i | input | 1 | Count half-cycle compares as opportunities |
| reload_freq_i | input | 4 | Reload every value+1 opportunities |
| imm_load_i | input | 1 | Immediate load mode |
| use_master_i | input | 1 | 1 selects master reload, 0 selects local reload |
| master_reload_i | input | 1 | Reload pulse from the primary submodule |
| ldok_set_i | input | 1 | Arms the load-okay flag |
| outer_wr_i | input | 1 | Write strobe for the outer register |
| outer_data_i | input | 16 | Outer register write data |
| load_strobe_o | output | 1 | One-cycle register-load strobe |
| reload_opp_o | output | 1 | Reload-opportunity pulse to the trigger unit |
| master_reload_o | output | 1 | Local reload broadcast to other submodules |
| ldok_o | output | 1 | Load-okay flag |
| active_o | output | 16 | Active (inner) register value |

## Verification
The bench cycles through every decimation value it uses: 0, 1 and 2. It checks that a counter which failed to restart on a reload, or which counted disabled compares, would put `reload_opp_o` on the wrong pulse. It fires reload events with load-okay clear, where a design missing the gate would change `active_o`. It also drives a set request in the same cycle as a load, where a design with the wrong priority would leave `ldok_o` high. It switches to master selection while local reloads keep occurring. A design that mixed up the two sources would load on local pulses or ignore the master pulse. It also checks that immediate mode still loads when both enables are clear.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_FREQ_W = 4;

    typedef struct packed {
        logic ldok;
        logic load;
    } ctrl_state_t;
endpackage

// File: rtl/reload_opp_counter.sv
module reload_opp_counter #(
    parameter int unsigned FREQ_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_cmp_i,
    input  logic              half_cmp_i,
    input  logic              full_en_i,
    input  logic              half_en_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              local_reload_o,
    output logic              opp_pulse_o
);
    typedef struct packed {
        logic [FREQ_W-1:0] cnt;
        logic              opp;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       opportunity;
    logic       wrap;

    always_comb begin
        opportunity = (full_cmp_i && full_en_i) || (half_cmp_i && half_en_i);
        wrap        = opportunity && (st_q.cnt >= freq_i);
        st_d        = st_q;
        st_d.opp    = wrap;
        if (wrap) begin
            st_d.cnt = '0;
        end else if (opportunity) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign local_reload_o = wrap;
    assign opp_pulse_o    = st_q.opp;

    assert_cnt_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.opp |-> (st_q.cnt == '0));

    assert_no_opp_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_en_i && !half_en_i) |=> !st_q.opp);
endmodule

// File: rtl/reload_buffer_reg.sv
module reload_buffer_reg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              load_en_i,
    output logic [DATA_W-1:0] outer_o,
    output logic [DATA_W-1:0] active_o
);
    typedef struct packed {
        logic [DATA_W-1:0] outer;
        logic [DATA_W-1:0] active;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.outer = wr_data_i;
        end
        if (load_en_i) begin
            st_d.active = st_q.outer;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign outer_o  = st_q.outer;
    assign active_o = st_q.active;
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
    import pwm_reload_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned FREQ_W = DEF_FREQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_cmp_i,
    input  logic              half_cmp_i,
    input  logic              full_en_i,
    input  logic              half_en_i,
    input  logic [FREQ_W-1:0] reload_freq_i,
    input  logic              imm_load_i,
    input  logic              use_master_i,
    input  logic              master_reload_i,
    input  logic              ldok_set_i,
    input  logic              outer_wr_i,
    input  logic [DATA_W-1:0] outer_data_i,
    output logic              load_strobe_o,
    output logic              reload_opp_o,
    output logic              master_reload_o,
    output logic              ldok_o,
    output logic [DATA_W-1:0] active_o
);
    ctrl_state_t       st_d, st_q;
    logic              local_reload;
    logic              opp_pulse;
    logic              sel_reload;
    logic              do_load;
    logic [DATA_W-1:0] outer_val;

    reload_opp_counter #(.FREQ_W(FREQ_W)) u_cnt (
        .clk            (clk),
        .rst_n          (rst_n),
        .full_cmp_i     (full_cmp_i),
        .half_cmp_i     (half_cmp_i),
        .full_en_i      (full_en_i),
        .half_en_i      (half_en_i),
        .freq_i         (reload_freq_i),
        .local_reload_o (local_reload),
        .opp_pulse_o    (opp_pulse)
    );

    always_comb begin
        sel_reload = use_master_i ? master_reload_i : local_reload;
        do_load    = st_q.ldok && (sel_reload || imm_load_i);
        st_d       = st_q;
        st_d.load  = do_load;
        if (do_load) begin
            st_d.ldok = 1'b0;
        end else if (ldok_set_i) begin
            st_d.ldok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    reload_buffer_reg #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (outer_wr_i),
        .wr_data_i (outer_data_i),
        .load_en_i (do_load),
        .outer_o   (outer_val),
        .active_o  (active_o)
    );

    assign load_strobe_o   = st_q.load;
    assign ldok_o          = st_q.ldok;
    assign reload_opp_o    = opp_pulse;
    assign master_reload_o = opp_pulse;

    assert_load_needs_ldok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe_o |-> $past(ldok_o));

    assert_ldok_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe_o |-> !ldok_o);

    assert_active_takes_outer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe_o |-> (active_o == $past(outer_val)));

    assert_active_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe_o |-> $stable(active_o));
endmodule

// File: tb/tb_pwm_reload_ctrl.sv
module tb_pwm_reload_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        full_cmp = 0, half_cmp = 0, full_en = 0, half_en = 0;
    logic [3:0]  freq = 0;
    logic        imm = 0, use_m = 0, m_rel = 0, ldok_set = 0, wr = 0;
    logic [15:0] wdata = 0;
    logic        load_strobe, opp, m_out, ldok;
    logic [15:0] active;

    logic       cfg_fe = 0, cfg_he = 0, cfg_imm = 0, cfg_um = 0;
    logic [3:0] cfg_freq = 0;
    string      cur_tag = "R1";

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        load;
        logic        opp;
        logic        ldok;
        logic [15:0] active;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    logic [3:0]  m_cnt = 0;
    logic        m_ldok = 0;
    logic [15:0] m_outer = 0, m_active = 0;

    always #5 clk = ~clk;

    pwm_reload_ctrl dut (
        .clk(clk), .rst_n(rst_n), .full_cmp_i(full_cmp), .half_cmp_i(half_cmp),
        .full_en_i(full_en), .half_en_i(half_en), .reload_freq_i(freq),
        .imm_load_i(imm), .use_master_i(use_m), .master_reload_i(m_rel),
        .ldok_set_i(ldok_set), .outer_wr_i(wr), .outer_data_i(wdata),
        .load_strobe_o(load_strobe), .reload_opp_o(opp), .master_reload_o(m_out),
        .ldok_o(ldok), .active_o(active)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic cyc(input logic fc, input logic hc, input logic w, input logic [15:0] wd,
                       input logic set, input logic mr);
        exp_t e;
        logic op, lr, sel, ld;
        @(negedge clk);
        full_cmp = fc; half_cmp = hc; wr = w; wdata = wd; ldok_set = set; m_rel = mr;
        full_en = cfg_fe; half_en = cfg_he; imm = cfg_imm; use_m = cfg_um; freq = cfg_freq;
        op  = (fc && cfg_fe) || (hc && cfg_he);
        lr  = op && (m_cnt >= cfg_freq);
        sel = cfg_um ? mr : lr;
        ld  = m_ldok && (sel || cfg_imm);
        if (lr) m_cnt = 0; else if (op) m_cnt = m_cnt + 1;
        if (ld) m_active = m_outer;
        if (w) m_outer = wd;
        if (ld) m_ldok = 0; else if (set) m_ldok = 1;
        e.load = ld; e.opp = lr; e.ldok = m_ldok; e.active = m_active; e.tag = cur_tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 16'h0, 0, 0);
    endtask

    // monitor: compares outputs just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, "load_strobe_o", {31'b0, load_strobe}, {31'b0, e.load});
                chk(e.tag, "reload_opp_o", {31'b0, opp}, {31'b0, e.opp});
                chk({e.tag, "/R8"}, "master_reload_o", {31'b0, m_out}, {31'b0, e.opp});
                chk(e.tag, "ldok_o", {31'b0, ldok}, {31'b0, e.ldok});
                chk(e.tag, "active_o", {16'b0, active}, {16'b0, e.active});
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "load_strobe_o", {31'b0, load_strobe}, 0);
        chk("R1", "reload_opp_o", {31'b0, opp}, 0);
        chk("R1", "ldok_o", {31'b0, ldok}, 0);
        chk("R1", "active_o", {16'b0, active}, 0);
        rst_n = 1'b1;
        idle(2);

        // R5: basic load with freq 0, full compares only
        cur_tag = "R5"; cfg_fe = 1; cfg_freq = 0;
        cyc(0, 0, 1, 16'hA5A5, 1, 0);
        cyc(1, 0, 0, 16'h0, 0, 0);
        idle(2);

        // R4: reload event without load-okay leaves active unchanged
        cur_tag = "R4";
        cyc(0, 0, 1, 16'h1234, 0, 0);
        cyc(1, 0, 0, 16'h0, 0, 0);
        idle(1);
        cyc(1, 0, 0, 16'h0, 0, 0);
        idle(1);

        // R5: set request in the same cycle as the load: clear wins
        cur_tag = "R5";
        cyc(0, 0, 0, 16'h0, 1, 0);
        cyc(1, 0, 0, 16'h0, 1, 0);
        idle(2);

        // R3/R10: freq 2, full only; half compares ignored (R2)
        cur_tag = "R3"; cfg_freq = 2;
        cyc(0, 0, 1, 16'h00C3, 1, 0);
        for (int k = 0; k < 7; k++) begin
            cyc(1, 0, 0, 16'h0, 0, 0);
            cyc(0, 1, 0, 16'h0, 0, 0);
        end
        cur_tag = "R10";
        cyc(0, 0, 0, 16'h0, 1, 0);
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 16'h0, 0, 0);
        idle(1);

        // R2: half only, freq 1; full compares ignored
        cur_tag = "R2"; cfg_fe = 0; cfg_he = 1; cfg_freq = 1;
        cyc(0, 0, 1, 16'h0F0F, 1, 0);
        for (int k = 0; k < 5; k++) begin
            cyc(1, 0, 0, 16'h0, 0, 0);
            cyc(0, 1, 0, 16'h0, 0, 0);
        end
        // R2: both enabled, simultaneous pulses count once
        cfg_fe = 1; cfg_freq = 1;
        cyc(0, 0, 0, 16'h0, 1, 0);
        cyc(1, 1, 0, 16'h0, 0, 0);
        cyc(1, 0, 0, 16'h0, 0, 0);
        cyc(0, 1, 0, 16'h0, 0, 0);
        cyc(1, 1, 0, 16'h0, 0, 0);
        idle(1);

        // R9/R6: both enables clear, compares ignored, immediate load works
        cur_tag = "R9"; cfg_fe = 0; cfg_he = 0; cfg_freq = 0;
        cyc(0, 0, 1, 16'h7777, 1, 0);
        cyc(1, 1, 0, 16'h0, 0, 0);
        cyc(1, 1, 0, 16'h0, 0, 0);
        cur_tag = "R6"; cfg_imm = 1;
        cyc(0, 0, 0, 16'h0, 0, 0);
        cyc(0, 0, 1, 16'h8888, 0, 0);
        cyc(0, 0, 0, 16'h0, 1, 0);
        idle(2);
        cfg_imm = 0;

        // R7: master select; local reloads give opportunities but no load
        cur_tag = "R7"; cfg_fe = 1; cfg_um = 1; cfg_freq = 0;
        cyc(0, 0, 1, 16'h4242, 1, 0);
        cyc(1, 0, 0, 16'h0, 0, 0);
        cyc(1, 0, 0, 16'h0, 0, 0);
        cyc(0, 0, 0, 16'h0, 0, 1);
        idle(1);
        // R7: local select ignores master input
        cfg_um = 0;
        cyc(0, 0, 1, 16'h5151, 1, 0);
        cyc(0, 0, 0, 16'h0, 0, 1);
        cyc(1, 0, 0, 16'h0, 0, 0);
        idle(3);

        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule